// File: doc/BRIEF.md
# Halfword Transfer Unit

This block carries out halfword moves on 36-bit words. Each request names a source half, a destination half and a fill rule. The source half is left or right. The destination half is left or right. The fill rule sets what goes into the destination half that does not receive the moved data. Each request also carries a two-bit mode tag that says where the result is going. The mode decides which input word supplies the moved half and which word supplies the kept half.

Bits are numbered from the most significant end. Bit 0 is the MSB. The left half is bits 0..17 and the right half is bits 18..35. All word ports are declared as ascending `[0:35]` vectors, so this numbering maps straight onto the port indices.

The block holds one output register behind a valid/ready handshake. The result comes out together with the mode tag that went in with it. Memory access and flag updates are handled elsewhere.

Top module: `hw_xfer_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0.
- R2: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. The result then shows one cycle later with `out_valid` high and `out_mode` equal to the accepted `in_mode`. If no request is taken while `in_ready` is high, `out_valid` drops.
- R3: While `out_valid` is high and `out_ready` is low, `out_word` and `out_valid` hold their values.
- R4: `in_src_half` and `in_dst_half` use 0 for the left half and 1 for the right half. The selected half of the moving word lands in the selected destination half. When the two selections differ, the half moves to the opposite position, as a swap would.
- R5: Fill code 0 (keep) in mode 0 (to accumulator) or mode 1 (immediate) takes the non-destination half from `in_acc`, at the same position. Both modes use `in_src` as the moving word.
- R6: Fill code 1 forces the non-destination half to all zeros.
- R7: Fill code 2 forces the non-destination half to all ones.
- R8: Fill code 3 copies the first bit of the moved half into every bit of the non-destination half. That is source bit 18 when the right half moves, and source bit 0 when the left half moves.
- R9: In mode 2 (to memory) the roles swap. The moved half comes from `in_acc`, and a keep fill takes the other half from `in_src`.
- R10: In mode 3 (self) the moved half and a kept half both come from `in_src`. A keep-fill move to the same half therefore returns `in_src` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_src | input | 36 | Source (memory or immediate) word, bit 0 is MSB |
| in_acc | input | 36 | Accumulator word, bit 0 is MSB |
| in_src_half | input | 1 | Half taken from the moving word: 0 left, 1 right |
| in_dst_half | input | 1 | Half written with the moved data: 0 left, 1 right |
| in_fill | input | 2 | Other-half rule: 0 keep, 1 zeros, 2 ones, 3 extend |
| in_mode | input | 2 | Mode tag: 0 accumulator, 1 immediate, 2 memory, 3 self |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_word | output | 36 | Registered result word |
| out_mode | output | 2 | Mode tag of the result |

## Verification
The bound checker watches the handshake on every cycle. It covers ready generation, result arrival one cycle after acceptance, the mode tag and stability under back-pressure. It also checks the zero, ones and sign fills and the accumulator keep-fill against the inputs sampled at acceptance. The exchange of roles in memory mode, the self-mode merges (including the unchanged same-half case) and the cross-half placement of the moved data are shown only by the bench's directed scenarios. Those scenarios compare whole result words against values worked out from the requirements.

// File: rtl/hw_pkg.sv
package hw_pkg;

    localparam int WORD_W = 36;
    localparam int HALF_W = WORD_W / 2;

    typedef logic [0:WORD_W-1] word_t;
    typedef logic [0:HALF_W-1] half_t;

    typedef enum logic {
        HALF_L = 1'b0,
        HALF_R = 1'b1
    } half_e;

    typedef enum logic [1:0] {
        FILL_KEEP = 2'd0,
        FILL_ZERO = 2'd1,
        FILL_ONES = 2'd2,
        FILL_EXT  = 2'd3
    } fill_e;

    typedef enum logic [1:0] {
        MD_ACC  = 2'd0,
        MD_IMM  = 2'd1,
        MD_MEM  = 2'd2,
        MD_SELF = 2'd3
    } mode_e;

    typedef struct packed {
        half_e src_half;
        half_e dst_half;
        fill_e fill;
    } xfer_op_t;

    function automatic half_t pick_half(input word_t w, input half_e sel);
        return (sel == HALF_R) ? w[HALF_W:WORD_W-1] : w[0:HALF_W-1];
    endfunction

    function automatic half_e other_half(input half_e h);
        return (h == HALF_R) ? HALF_L : HALF_R;
    endfunction

endpackage

// File: rtl/hw_operand_sel.sv
module hw_operand_sel
    import hw_pkg::*;
(
    input  mode_e mode,
    input  word_t src_word,
    input  word_t acc_word,
    output word_t mover,
    output word_t base
);
    // Chooses the word the moved half is taken from and the word
    // that supplies a kept half, according to the destination mode.
    always_comb begin
        unique case (mode)
            MD_MEM: begin
                mover = acc_word;
                base  = src_word;
            end
            MD_SELF: begin
                mover = src_word;
                base  = src_word;
            end
            default: begin
                mover = src_word;
                base  = acc_word;
            end
        endcase
    end
endmodule

// File: rtl/hw_half_merge.sv
module hw_half_merge
    import hw_pkg::*;
(
    input  word_t    mover,
    input  word_t    base,
    input  xfer_op_t op,
    output word_t    result
);
    half_t moved;
    half_t filler;

    assign moved = pick_half(mover, op.src_half);

    always_comb begin
        unique case (op.fill)
            FILL_KEEP: filler = pick_half(base, other_half(op.dst_half));
            FILL_ZERO: filler = '0;
            FILL_ONES: filler = '1;
            default:   filler = {HALF_W{moved[0]}};
        endcase
    end

    // One slot per destination half: either the moved data or the filler.
    for (genvar h = 0; h < 2; h++) begin : g_slot
        localparam half_e SLOT = (h == 1) ? HALF_R : HALF_L;
        assign result[h*HALF_W +: HALF_W] = (op.dst_half == SLOT) ? moved : filler;
    end
endmodule

// File: rtl/hw_out_stage.sv
module hw_out_stage
    import hw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  d_valid,
    output logic  d_ready,
    input  word_t d_word,
    input  mode_e d_mode,
    output logic  q_valid,
    input  logic  q_ready,
    output word_t q_word,
    output mode_e q_mode
);
    assign d_ready = !q_valid || q_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_word  <= '0;
            q_mode  <= MD_ACC;
        end else begin
            if (d_ready) begin
                q_valid <= d_valid;
            end
            if (d_valid && d_ready) begin
                q_word <= d_word;
                q_mode <= d_mode;
            end
        end
    end
endmodule

// File: rtl/hw_xfer_unit.sv
module hw_xfer_unit
    import hw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [0:35]     in_src,
    input  logic [0:35]     in_acc,
    input  logic            in_src_half,
    input  logic            in_dst_half,
    input  logic [1:0]      in_fill,
    input  logic [1:0]      in_mode,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [0:35]     out_word,
    output logic [1:0]      out_mode
);
    xfer_op_t op;
    mode_e    mode_in;
    mode_e    mode_q;
    word_t    mover;
    word_t    base;
    word_t    merged;
    word_t    word_q;

    assign op.src_half = half_e'(in_src_half);
    assign op.dst_half = half_e'(in_dst_half);
    assign op.fill     = fill_e'(in_fill);
    assign mode_in     = mode_e'(in_mode);

    hw_operand_sel u_sel (
        .mode     (mode_in),
        .src_word (in_src),
        .acc_word (in_acc),
        .mover    (mover),
        .base     (base)
    );

    hw_half_merge u_merge (
        .mover  (mover),
        .base   (base),
        .op     (op),
        .result (merged)
    );

    hw_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .d_valid (in_valid),
        .d_ready (in_ready),
        .d_word  (merged),
        .d_mode  (mode_in),
        .q_valid (out_valid),
        .q_ready (out_ready),
        .q_word  (word_q),
        .q_mode  (mode_q)
    );

    assign out_word = word_q;
    assign out_mode = mode_q;
endmodule

// File: rtl/hw_xfer_unit_chk.sv
module hw_xfer_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic [0:35] in_src,
    input logic [0:35] in_acc,
    input logic        in_src_half,
    input logic        in_dst_half,
    input logic [1:0]  in_fill,
    input logic [1:0]  in_mode,
    input logic        out_valid,
    input logic        out_ready,
    input logic [0:35] out_word,
    input logic [1:0]  out_mode
);
    logic take;
    assign take = in_valid && in_ready;

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> !out_valid);

    // R2
    ready_open_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    // R2
    accept_result_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> out_valid && out_mode == $past(in_mode));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_word));

    // R6
    zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        take && in_fill == 2'd1 && !in_dst_half |=> out_word[18:35] == 18'h0);

    // R7
    ones_fill_chk: assert property (@(posedge clk) disable iff (rst)
        take && in_fill == 2'd2 && in_dst_half |=> out_word[0:17] == 18'h3ffff);

    // R8
    sign_fill_chk: assert property (@(posedge clk) disable iff (rst)
        take && in_fill == 2'd3 && in_mode != 2'd2 && in_dst_half |=>
        out_word[0:17] == {18{$past(in_src_half ? in_src[18] : in_src[0])}});

    // R5
    acc_keep_chk: assert property (@(posedge clk) disable iff (rst)
        take && in_fill == 2'd0 && in_mode == 2'd0 && !in_dst_half |=>
        out_word[18:35] == $past(in_acc[18:35]));
endmodule

bind hw_xfer_unit hw_xfer_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_src      (in_src),
    .in_acc      (in_acc),
    .in_src_half (in_src_half),
    .in_dst_half (in_dst_half),
    .in_fill     (in_fill),
    .in_mode     (in_mode),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_word    (out_word),
    .out_mode    (out_mode)
);

// File: tb/hw_xfer_unit_tb.sv
module hw_xfer_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [0:35] in_src = '0;
    logic [0:35] in_acc = '0;
    logic        in_src_half = 1'b0;
    logic        in_dst_half = 1'b0;
    logic [1:0]  in_fill = 2'd0;
    logic [1:0]  in_mode = 2'd0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [0:35] out_word;
    logic [1:0]  out_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [0:35] SRC = 36'o123456_765432;
    localparam logic [0:35] ACC = 36'o555555_222222;

    always #5 clk = ~clk;

    hw_xfer_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_src(in_src), .in_acc(in_acc), .in_src_half(in_src_half),
        .in_dst_half(in_dst_half), .in_fill(in_fill), .in_mode(in_mode),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_word(out_word), .out_mode(out_mode)
    );

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %o expected %o", req, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [0:35] s, input logic [0:35] a,
                          input logic sh, input logic dh, input logic [1:0] f,
                          input logic [1:0] m, input logic [0:35] exp);
        @(negedge clk);
        in_src = s; in_acc = a; in_src_half = sh; in_dst_half = dh;
        in_fill = f; in_mode = m; in_valid = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {35'd0, out_valid}, 36'd1);
        check({req, " word"}, out_word, exp);
        check({req, " mode"}, {34'd0, out_mode}, {34'd0, m});
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {35'd0, out_valid}, 36'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", {35'd0, out_valid}, 36'd0);
        check("R2 ready when idle", {35'd0, in_ready}, 36'd1);
    endtask

    task automatic t_acc_modes;
        run_op("R4 R5 cross right to left keep", SRC, ACC, 1'b1, 1'b0, 2'd0, 2'd0, 36'o765432_222222);
        run_op("R4 R5 left to left keep", SRC, ACC, 1'b0, 1'b0, 2'd0, 2'd0, 36'o123456_222222);
        run_op("R5 immediate right keep", SRC, ACC, 1'b1, 1'b1, 2'd0, 2'd1, 36'o555555_765432);
        run_op("R6 zero fill", SRC, ACC, 1'b1, 1'b1, 2'd1, 2'd0, 36'o000000_765432);
        run_op("R7 ones fill", SRC, ACC, 1'b0, 1'b1, 2'd2, 2'd0, 36'o777777_123456);
        run_op("R8 extend from bit 18", SRC, ACC, 1'b1, 1'b0, 2'd3, 2'd0, 36'o765432_777777);
        run_op("R8 extend from bit 0", SRC, ACC, 1'b0, 1'b1, 2'd3, 2'd1, 36'o000000_123456);
    endtask

    task automatic t_mem_mode;
        run_op("R9 memory keep", SRC, ACC, 1'b0, 1'b1, 2'd0, 2'd2, 36'o123456_555555);
        run_op("R9 memory zero", SRC, ACC, 1'b1, 1'b0, 2'd1, 2'd2, 36'o222222_000000);
    endtask

    task automatic t_self_mode;
        run_op("R10 self same half unchanged", SRC, ACC, 1'b0, 1'b0, 2'd0, 2'd3, SRC);
        run_op("R10 self cross keep", SRC, ACC, 1'b1, 1'b0, 2'd0, 2'd3, 36'o765432_765432);
        run_op("R10 self extend", SRC, ACC, 1'b1, 1'b1, 2'd3, 2'd3, 36'o777777_765432);
    endtask

    task automatic t_stall;
        run_op("R3 first word", SRC, ACC, 1'b1, 1'b1, 2'd1, 2'd0, 36'o000000_765432);
        out_ready = 1'b0;
        in_src = ACC; in_src_half = 1'b0; in_dst_half = 1'b0;
        in_fill = 2'd2; in_mode = 2'd1; in_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R2 ready low under stall", {35'd0, in_ready}, 36'd0);
            check("R3 word held", out_word, 36'o000000_765432);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 second word", out_word, 36'o555555_777777);
        check("R2 second mode", {34'd0, out_mode}, 36'd1);
        @(negedge clk);
        check("R2 valid drops", {35'd0, out_valid}, 36'd0);
    endtask

    initial begin
        t_reset();
        t_acc_modes();
        t_mem_mode();
        t_self_mode();
        t_stall();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule